// File: doc/BRIEF.md
# Segmented Parallel Prefix Scan Unit

This unit takes a vector of sixteen 16-bit lanes and returns, for every lane, the exclusive prefix of the lanes that come before it in the chosen scan direction. Alongside the prefix vector, it returns one value that folds all sixteen lanes together. Five combining operators are available: wrapping sum, signed maximum, signed minimum, bitwise AND and bitwise OR. The scan runs either forward, from lane 0 upward, or backward, from lane 15 downward.

A per-lane flag vector cuts a long vector into independent sections. Each flag marks the lowest-indexed lane of a section. The same sections apply in both directions. In every section, the first lane in scan direction receives the identity of the operator.

A vector enters through a valid/ready handshake. Its results stand on the output one cycle later and stay there until the consumer takes them. A new vector can enter in the same cycle that the previous result leaves, so the unit sustains one vector per cycle.

Top module: `seg_scan_unit`

## Requirements
- R1: After reset, `out_valid_o` is low and `in_ready_o` is high.
- R2: A vector accepted at a clock edge (`in_valid_i` and `in_ready_o` both high) has its results valid on `out_valid_o` right after that edge. `in_ready_o` is high whenever the output holds nothing or is being taken in the same cycle.
- R3: While `out_valid_o` is high and `out_ready_i` is low, `prefix_o`, `reduce_o` and `out_valid_o` hold their values, and `in_ready_o` is low.
- R4: `op_i` selects the operator: 0 is sum modulo 2^16, 1 is signed two's-complement maximum, 2 is signed minimum, 3 is bitwise AND, 4 is bitwise OR. The codes 5 to 7 behave as sum.
- R5: With `dir_i` = 0, lane i of `prefix_o` combines the input lanes from its section start up to lane i-1. Lane i occupies bits [16i+15:16i] of both `lanes_i` and `prefix_o`.
- R6: With `dir_i` = 1, lane i combines the input lanes from lane i+1 up to the last lane of its section. A section ends at lane 15 or just before the next flagged lane.
- R7: `seg_i` bit i = 1 makes lane i the first (lowest) lane of a new section, and accumulation restarts there. Lane 0 always starts a section, whatever `seg_i` bit 0 holds.
- R8: The first lane of a section in scan direction outputs the identity of the operator: 0x0000 for sum and OR, 0xFFFF for AND, 0x8000 for maximum, 0x7FFF for minimum.
- R9: `reduce_o` combines all sixteen lanes with the selected operator, regardless of `seg_i` and `dir_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector is present |
| in_ready_o | output | 1 | Unit can take a vector |
| lanes_i | input | 256 | Sixteen 16-bit lanes, lane 0 in the low bits |
| seg_i | input | 16 | Section-start flags, one per lane |
| op_i | input | 3 | Operator code |
| dir_i | input | 1 | 0 = forward, 1 = backward |
| out_valid_o | output | 1 | Results are present |
| out_ready_i | input | 1 | Consumer takes the results |
| prefix_o | output | 256 | Exclusive prefix per lane |
| reduce_o | output | 16 | Reduction of all lanes |

## Verification
Every result is due on the cycle right after its vector is accepted. The bench records the cycle number at each acceptance and checks that the matching result first becomes visible exactly one cycle later. It samples both sides one nanosecond before each rising edge, so the values it sees are the ones the next edge acts on. Under random backpressure, it compares every stalled cycle against the cycle before it. The prefix and reduction values are compared only in the cycle where the consumer takes them.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  typedef enum logic [2:0] {
    OP_SUM = 3'd0,
    OP_MAX = 3'd1,
    OP_MIN = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4
  } scan_op_e;
endpackage

// File: rtl/seg_scan_combine.sv
module seg_scan_combine
  import seg_scan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_MAX:  y_o = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
      OP_MIN:  y_o = ($signed(a_i) < $signed(b_i)) ? a_i : b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      default: y_o = a_i + b_i;  // sum, also for spare codes
    endcase
  end
endmodule

// File: rtl/seg_scan_chain.sv
// Exclusive segmented scan; backward runs the forward chain on mirrored lanes.
module seg_scan_chain #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic [2:0]     op_i,
  input  logic           dir_i,
  input  logic [W-1:0]   id_i,
  input  logic [N*W-1:0] x_i,
  input  logic [N-1:1]   seg_i,
  output logic [N*W-1:0] prefix_o
);
  logic [N-1:0][W-1:0] rx;
  logic [N-1:0]        rs;
  logic [N-1:0][W-1:0] acc;
  logic [N-1:0][W-1:0] cmb;

  always_comb begin
    rs[0] = 1'b1;
    for (int i = 0; i < N; i++) begin
      rx[i] = dir_i ? x_i[(N-1-i)*W +: W] : x_i[i*W +: W];
    end
    for (int i = 1; i < N; i++) begin
      rs[i] = dir_i ? seg_i[N-i] : seg_i[i];
    end
  end

  assign acc[0] = id_i;
  assign cmb[0] = id_i;

  for (genvar j = 1; j < N; j++) begin : g_stage
    seg_scan_combine #(.W(W)) u_cmb (
      .op_i (op_i),
      .a_i  (acc[j-1]),
      .b_i  (rx[j-1]),
      .y_o  (cmb[j])
    );
    assign acc[j] = rs[j] ? id_i : cmb[j];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      prefix_o[i*W +: W] = dir_i ? acc[N-1-i] : acc[i];
    end
  end
endmodule

// File: rtl/seg_scan_tree.sv
module seg_scan_tree #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic [2:0]     op_i,
  input  logic [W-1:0]   id_i,
  input  logic [N*W-1:0] x_i,
  output logic [W-1:0]   red_o
);
  localparam int P = 1 << $clog2(N);

  logic [W-1:0] node [1:2*P-1];

  for (genvar l = 0; l < P; l++) begin : g_leaf
    if (l < N) begin : g_lane
      assign node[P+l] = x_i[l*W +: W];
    end else begin : g_pad
      assign node[P+l] = id_i;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    seg_scan_combine #(.W(W)) u_cmb (
      .op_i (op_i),
      .a_i  (node[2*k]),
      .b_i  (node[2*k+1]),
      .y_o  (node[k])
    );
  end

  assign red_o = node[1];
endmodule

// File: rtl/seg_scan_unit.sv
module seg_scan_unit
  import seg_scan_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [N*W-1:0] lanes_i,
  input  logic [N-1:0]   seg_i,
  input  logic [2:0]     op_i,
  input  logic           dir_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [N*W-1:0] prefix_o,
  output logic [W-1:0]   reduce_o
);
  logic           vld_q;
  logic [N*W-1:0] x_q;
  logic [N-1:1]   seg_q;
  logic [2:0]     op_q;
  logic           dir_q;
  logic [W-1:0]   id;
  logic           accept;
  logic           unused_seg0;

  assign unused_seg0 = seg_i[0];  // lane 0 always starts a section
  assign in_ready_o  = !vld_q || out_ready_i;
  assign accept      = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      seg_q <= '0;
      op_q  <= '0;
      dir_q <= 1'b0;
    end else if (accept) begin
      vld_q <= 1'b1;
      x_q   <= lanes_i;
      seg_q <= seg_i[N-1:1];
      op_q  <= op_i;
      dir_q <= dir_i;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  always_comb begin
    case (op_q)
      OP_MAX:  id = {1'b1, {(W-1){1'b0}}};
      OP_MIN:  id = {1'b0, {(W-1){1'b1}}};
      OP_AND:  id = '1;
      default: id = '0;
    endcase
  end

  seg_scan_chain #(.N(N), .W(W)) u_chain (
    .op_i     (op_q),
    .dir_i    (dir_q),
    .id_i     (id),
    .x_i      (x_q),
    .seg_i    (seg_q),
    .prefix_o (prefix_o)
  );

  seg_scan_tree #(.N(N), .W(W)) u_tree (
    .op_i  (op_q),
    .id_i  (id),
    .x_i   (x_q),
    .red_o (reduce_o)
  );

  assign out_valid_o = vld_q;

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(prefix_o) && $stable(reduce_o));

  assert_fwd_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !dir_q |-> prefix_o[W-1:0] == id);

  assert_bwd_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && dir_q |-> prefix_o[(N-1)*W +: W] == id);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_max_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && op_q == OP_MAX |-> $signed(reduce_o) >= $signed(x_q[i*W +: W]));
  end
endmodule

// File: tb/seg_scan_unit_tb.sv
module seg_scan_unit_tb;
  localparam int N = 16;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N*W-1:0] lanes = '0;
  logic [N-1:0]   seg = '0;
  logic [2:0]     op = '0;
  logic           dir = 1'b0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [N*W-1:0] prefix;
  logic [W-1:0]   red;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [N*W-1:0] exp_pre [$];
  logic [W-1:0]   exp_red [$];
  string          exp_tag [$];
  int             exp_cyc [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seg_scan_unit #(.N(N), .W(W)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_ready_o (in_ready),
    .lanes_i (lanes), .seg_i (seg), .op_i (op), .dir_i (dir),
    .out_valid_o (out_valid), .out_ready_i (out_ready),
    .prefix_o (prefix), .reduce_o (red)
  );

  function automatic logic [W-1:0] m_ident(input logic [2:0] o);
    case (o)
      3'd1: return 16'h8000;
      3'd2: return 16'h7FFF;
      3'd3: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [W-1:0] m_comb(input logic [2:0] o, input logic [W-1:0] a, b);
    case (o)
      3'd1: return ($signed(a) >= $signed(b)) ? a : b;
      3'd2: return ($signed(a) <= $signed(b)) ? a : b;
      3'd3: return a & b;
      3'd4: return a | b;
      default: return a + b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [N*W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [N*W-1:0] x, input logic [N-1:0] s,
                      input logic [2:0] o, input logic d, input string tag);
    logic [N*W-1:0] p;
    logic [W-1:0] acc;
    bit ok;
    acc = m_ident(o);
    if (!d) begin
      for (int i = 0; i < N; i++) begin
        if (i == 0 || s[i]) acc = m_ident(o);
        p[i*W +: W] = acc;
        acc = m_comb(o, acc, x[i*W +: W]);
      end
    end else begin
      for (int i = N-1; i >= 0; i--) begin
        if (i == N-1 || s[i+1]) acc = m_ident(o);
        p[i*W +: W] = acc;
        acc = m_comb(o, acc, x[i*W +: W]);
      end
    end
    acc = m_ident(o);
    for (int i = 0; i < N; i++) acc = m_comb(o, acc, x[i*W +: W]);
    @(negedge clk);
    in_valid = 1'b1; lanes = x; seg = s; op = o; dir = d;
    ok = 1'b0;
    while (!ok) begin
      #4;
      ok = in_ready;
      if (!ok) @(negedge clk);
    end
    exp_pre.push_back(p); exp_red.push_back(acc);
    exp_tag.push_back(tag); exp_cyc.push_back(cyc);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor: samples 1 ns before each rising edge
  initial begin
    bit fresh = 1'b1;
    bit prev_stall = 1'b0;
    logic [N*W-1:0] prev_pre = '0;
    logic [W-1:0] prev_red = '0;
    forever begin
      @(negedge clk); #4;
      if (rst_n) begin
        if (prev_stall) begin
          chk(out_valid && prefix == prev_pre && red == prev_red, "R3 hold",
              {prefix, 15'd0, out_valid}, {prev_pre, 16'd1});
        end
        if (out_valid && !out_ready)
          chk(in_ready == 1'b0, "R3 ready low", in_ready, 0);
        if (!out_valid || out_ready)
          chk(in_ready == 1'b1, "R2 ready high", in_ready, 1);
        if (out_valid) begin
          if (exp_pre.size() == 0) begin
            chk(1'b0, "R2 unexpected result", 1, 0);
          end else begin
            if (fresh) begin
              chk(cyc == exp_cyc[0] + 1, "R2 latency", cyc, exp_cyc[0] + 1);
              fresh = 1'b0;
            end
            if (out_ready) begin
              chk(prefix === exp_pre[0], exp_tag[0], prefix, exp_pre[0]);
              chk(red === exp_red[0], "R9 reduce", red, exp_red[0]);
              void'(exp_pre.pop_front()); void'(exp_red.pop_front());
              void'(exp_tag.pop_front()); void'(exp_cyc.pop_front());
              fresh = 1'b1;
            end
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_pre = prefix;
        prev_red = red;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] v;
    repeat (3) @(negedge clk);
    #4;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) v[i*W +: W] = 16'(i + 1);
    send(v, 16'h0000, 3'd0, 1'b0, "R5 fwd sum");
    send(v, 16'h0110, 3'd0, 1'b0, "R7 fwd sections");
    send(v, 16'h0111, 3'd0, 1'b0, "R7 lane0 flag");
    send(v, 16'h0110, 3'd0, 1'b1, "R6 bwd sections");
    send(v, 16'h0000, 3'd0, 1'b1, "R6 bwd sum");
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'((i * 37) % 11 - 8);
    send(v, 16'h0000, 3'd1, 1'b0, "R8 max identity");
    send(v, 16'h8001, 3'd2, 1'b1, "R8 min identity");
    send(v, 16'h0000, 3'd4, 1'b0, "R8 or identity");
    send(v, 16'h0000, 3'd3, 1'b1, "R8 and identity");
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'hFFF0 + 16'(i);
    send(v, 16'h0000, 3'd0, 1'b0, "R4 sum wrap");
    send(v, 16'h0420, 3'd5, 1'b1, "R4 spare code");
    send(v, 16'h1204, 3'd3, 1'b0, "R4 and");
    send(v, 16'h0810, 3'd4, 1'b1, "R4 or");
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'($urandom);
    send(v, 16'h2222, 3'd1, 1'b1, "R4 max");
    send(v, 16'h4004, 3'd2, 1'b0, "R4 min");

    stall_en = 1'b1;
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = 16'($urandom);
      send(v, 16'($urandom), 3'($urandom % 8), 1'($urandom), "R3 stalled stream");
    end
    while (exp_pre.size() != 0) @(negedge clk);
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule